// File: doc/BRIEF.md
# Bitwise Three-Input Lookup Unit

This unit applies an arbitrary three-input boolean function to every bit position of its operands at once. Each bit slice is a tiny lookup table: three operand bits form a 3-bit index, and that index picks one bit out of an 8-bit truth table. The same table serves every slice, so one table constant gives AND, OR, XOR, majority, select (mux) or any other three-input function across the whole word.

There are three operating modes. In the immediate mode the table comes from an 8-bit instruction immediate. In the register-table mode it comes from the low byte of a fourth register operand. In the condition-field mode the unit works on three 4-bit condition fields instead of data words, and a per-bit write mask decides which positions of the destination field are rewritten. The destination's old value is one of the three index inputs in every mode.

The result is captured in an output register, so a result appears one clock after its valid strobe. Decode and register-file access are handled elsewhere. The caller feeds the unit operands, a mode and a table source, and takes the result word or field from the outputs.

Top module: `tri_lut_unit`

## Requirements
- R1: In mode 2'b00 (immediate), output bit i equals `tbl_imm[idx]` with `idx = {op_dst[i], op_a[i], op_b[i]}` (old destination is index bit 2, `op_a` bit 1, `op_b` bit 0). The table is indexed from its least significant bit, so 0xF0 passes `op_dst`, 0xCC passes `op_a` and 0xAA passes `op_b`.
- R2: One 8-bit table applies independently and in parallel to all DATA_W bit positions. Every one of the 256 table values gives the bitwise function that its truth table defines.
- R3: In mode 2'b01 (register table), the table is `op_tbl_lo` (the low byte of the fourth register), indexed as in R1. `tbl_imm` has no effect in this mode.
- R4: In mode 2'b10 (condition field), for each field position i with `cr_mask[i]` = 1, `out_cr[i]` equals `tbl_imm[{cr_dst[i], cr_b[i], cr_c[i]}]`.
- R5: In mode 2'b10, each field position i with `cr_mask[i]` = 0 keeps its old value `cr_dst[i]`.
- R6: Mode 2'b11 is reserved and yields `out_word` = 0 and `out_cr` = 0.
- R7: `out_valid` is `in_valid` delayed by exactly one clock. The word modes drive `out_cr` to 0, and the condition-field mode drives `out_word` to 0.
- R8: While `in_valid` is low, `out_word` and `out_cr` keep their last values.
- R9: After reset, `out_valid`, `out_word` and `out_cr` are all 0.
- R10: A bitwise select (take `op_dst` where `op_a` is 1, else `op_b`) is given by the immediate table 0xE2, with no dedicated mux operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 00 immediate, 01 register table, 10 condition field, 11 reserved |
| tbl_imm | input | 8 | Immediate truth table (modes 00 and 10) |
| op_tbl_lo | input | 8 | Low byte of the fourth register, used as the table in mode 01 |
| op_dst | input | DATA_W | Old destination value, index bit 2 |
| op_a | input | DATA_W | First source, index bit 1 |
| op_b | input | DATA_W | Second source, index bit 0 |
| cr_dst | input | CRF_W | Destination condition field, index bit 2 and kept value |
| cr_b | input | CRF_W | Second condition field, index bit 1 |
| cr_c | input | CRF_W | Third condition field, index bit 0 |
| cr_mask | input | CRF_W | Per-position write mask for the condition field |
| out_valid | output | 1 | Result registers were loaded on the last clock |
| out_word | output | DATA_W | Registered word result |
| out_cr | output | CRF_W | Registered condition-field result |

## Verification
The checker watches, on every cycle, the one-cycle valid latency, that results hold while idle, that the reserved mode gives zero, that masked-off condition positions keep their old value, and that the three identity tables and the all-zero and all-one tables give their fixed results. Only the bench's scenarios can show the full mapping of every table value to its bitwise function, the register-table source, the select table 0xE2, and the exact rewritten condition bits. These are checked against a bit-level reference model over all 256 tables with random operands, and against hand-worked vectors.

// File: rtl/tri_lut_pkg.sv
package tri_lut_pkg;

    localparam int LUT_IN = 3;
    localparam int TBL_W  = 1 << LUT_IN;

    typedef enum logic [1:0] {
        MODE_IMM    = 2'b00,
        MODE_REGTBL = 2'b01,
        MODE_CRF    = 2'b10,
        MODE_RSVD   = 2'b11
    } tlu_mode_e;

endpackage

// File: rtl/tri_lut_cell.sv
module tri_lut_cell
    import tri_lut_pkg::*;
(
    input  logic [TBL_W-1:0] table_bits,
    input  logic             sel_hi,
    input  logic             sel_mid,
    input  logic             sel_lo,
    output logic             y
);
    logic [LUT_IN-1:0] idx;

    always_comb begin
        idx = {sel_hi, sel_mid, sel_lo};
        y   = table_bits[idx];
    end
endmodule

// File: rtl/tri_lut_word_plane.sv
module tri_lut_word_plane
    import tri_lut_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [TBL_W-1:0]  table_bits,
    input  logic [DATA_W-1:0] w_dst,
    input  logic [DATA_W-1:0] w_a,
    input  logic [DATA_W-1:0] w_b,
    output logic [DATA_W-1:0] w_res
);
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        tri_lut_cell u_cell (
            .table_bits (table_bits),
            .sel_hi     (w_dst[gi]),
            .sel_mid    (w_a[gi]),
            .sel_lo     (w_b[gi]),
            .y          (w_res[gi])
        );
    end
endmodule

// File: rtl/tri_lut_cr_plane.sv
module tri_lut_cr_plane
    import tri_lut_pkg::*;
#(
    parameter int CRF_W = 4
) (
    input  logic [TBL_W-1:0] table_bits,
    input  logic [CRF_W-1:0] f_dst,
    input  logic [CRF_W-1:0] f_b,
    input  logic [CRF_W-1:0] f_c,
    input  logic [CRF_W-1:0] f_mask,
    output logic [CRF_W-1:0] f_res
);
    for (genvar gi = 0; gi < CRF_W; gi++) begin : g_pos
        logic lut_y;

        tri_lut_cell u_cell (
            .table_bits (table_bits),
            .sel_hi     (f_dst[gi]),
            .sel_mid    (f_b[gi]),
            .sel_lo     (f_c[gi]),
            .y          (lut_y)
        );

        assign f_res[gi] = f_mask[gi] ? lut_y : f_dst[gi];
    end
endmodule

// File: rtl/tri_lut_unit.sv
module tri_lut_unit
    import tri_lut_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CRF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [TBL_W-1:0]  tbl_imm,
    input  logic [TBL_W-1:0]  op_tbl_lo,
    input  logic [DATA_W-1:0] op_dst,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [CRF_W-1:0]  cr_dst,
    input  logic [CRF_W-1:0]  cr_b,
    input  logic [CRF_W-1:0]  cr_c,
    input  logic [CRF_W-1:0]  cr_mask,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_word,
    output logic [CRF_W-1:0]  out_cr
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] word;
        logic [CRF_W-1:0]  cr;
    } res_state_t;

    localparam res_state_t RES_RESET = '{valid: 1'b0, word: '0, cr: '0};

    res_state_t st_d, st_q;

    tlu_mode_e         mode_sel;
    logic [TBL_W-1:0]  word_table;
    logic [DATA_W-1:0] word_res;
    logic [CRF_W-1:0]  cr_res;

    always_comb begin
        mode_sel   = tlu_mode_e'(mode);
        word_table = (mode_sel == MODE_REGTBL) ? op_tbl_lo : tbl_imm;
    end

    tri_lut_word_plane #(
        .DATA_W (DATA_W)
    ) u_word_plane (
        .table_bits (word_table),
        .w_dst      (op_dst),
        .w_a        (op_a),
        .w_b        (op_b),
        .w_res      (word_res)
    );

    tri_lut_cr_plane #(
        .CRF_W (CRF_W)
    ) u_cr_plane (
        .table_bits (tbl_imm),
        .f_dst      (cr_dst),
        .f_b        (cr_b),
        .f_c        (cr_c),
        .f_mask     (cr_mask),
        .f_res      (cr_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            unique case (mode_sel)
                MODE_IMM, MODE_REGTBL: begin
                    st_d.word = word_res;
                    st_d.cr   = '0;
                end
                MODE_CRF: begin
                    st_d.word = '0;
                    st_d.cr   = cr_res;
                end
                default: begin
                    st_d.word = '0;
                    st_d.cr   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RES_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;
    assign out_cr    = st_q.cr;
endmodule

// File: rtl/tri_lut_chk.sv
module tri_lut_chk #(
    parameter int DATA_W = 64,
    parameter int CRF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        mode,
    input logic [7:0]        tbl_imm,
    input logic [DATA_W-1:0] op_dst,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [CRF_W-1:0]  cr_dst,
    input logic [CRF_W-1:0]  cr_mask,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_word,
    input logic [CRF_W-1:0]  out_cr
);
    logic imm_go;
    assign imm_go = in_valid && (mode == 2'b00);

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid latency"); // R7
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("valid drop"); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_word) && $stable(out_cr))) else $error("hold"); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b11) |=> (out_word == '0 && out_cr == '0)) else $error("rsvd"); // R6
    AST_CRF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b10) |=> (((out_cr ^ $past(cr_dst)) & ~$past(cr_mask)) == '0)) else $error("keep"); // R5
    AST_CRF_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b10) |=> (out_word == '0)) else $error("crf word"); // R7
    AST_ID_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_go && tbl_imm == 8'hF0) |=> (out_word == $past(op_dst))) else $error("id dst"); // R1
    AST_ID_SRCA: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_go && tbl_imm == 8'hCC) |=> (out_word == $past(op_a))) else $error("id a"); // R1
    AST_ID_SRCB: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_go && tbl_imm == 8'hAA) |=> (out_word == $past(op_b))) else $error("id b"); // R1
    AST_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_go && tbl_imm == 8'hFF) |=> (out_word == '1 && out_cr == '0)) else $error("ones"); // R2
    AST_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_go && tbl_imm == 8'h00) |=> (out_word == '0)) else $error("zeros"); // R2
endmodule

bind tri_lut_unit tri_lut_chk #(
    .DATA_W (DATA_W),
    .CRF_W  (CRF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .tbl_imm   (tbl_imm),
    .op_dst    (op_dst),
    .op_a      (op_a),
    .op_b      (op_b),
    .cr_dst    (cr_dst),
    .cr_mask   (cr_mask),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_cr    (out_cr)
);

// File: tb/tri_lut_unit_tb.sv
module tri_lut_unit_tb;
    localparam int DW = 64;
    localparam int CW = 4;

    typedef struct packed {
        logic [1:0]    md;
        logic [7:0]    imm;
        logic [7:0]    tbl;
        logic [DW-1:0] d;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [CW-1:0] cd;
        logic [CW-1:0] cb;
        logic [CW-1:0] cc;
        logic [CW-1:0] cm;
        logic [DW-1:0] ew;
        logic [CW-1:0] ec;
        logic [7:0]    rq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        // R1: 0xF0 passes old destination
        '{2'b00, 8'hF0, 8'h00, 64'h0123456789ABCDEF, 64'hFFFF0000FFFF0000, 64'h00FF00FF00FF00FF,
          4'h0, 4'h0, 4'h0, 4'h0, 64'h0123456789ABCDEF, 4'h0, 8'd1},
        // R1: 0xCC passes op_a
        '{2'b00, 8'hCC, 8'h00, 64'h0123456789ABCDEF, 64'hFFFF0000FFFF0000, 64'h00FF00FF00FF00FF,
          4'h0, 4'h0, 4'h0, 4'h0, 64'hFFFF0000FFFF0000, 4'h0, 8'd1},
        // R1: 0xAA passes op_b
        '{2'b00, 8'hAA, 8'h00, 64'h0123456789ABCDEF, 64'hFFFF0000FFFF0000, 64'h00FF00FF00FF00FF,
          4'h0, 4'h0, 4'h0, 4'h0, 64'h00FF00FF00FF00FF, 4'h0, 8'd1},
        // R2: constant tables
        '{2'b00, 8'h00, 8'hFF, 64'h0123456789ABCDEF, 64'h1, 64'h2,
          4'hF, 4'hF, 4'hF, 4'hF, 64'h0, 4'h0, 8'd2},
        '{2'b00, 8'hFF, 8'h00, 64'h0, 64'h0, 64'h0,
          4'h0, 4'h0, 4'h0, 4'h0, 64'hFFFFFFFFFFFFFFFF, 4'h0, 8'd2},
        // R3: register table 0x96 = three-way XOR, immediate ignored
        '{2'b01, 8'h00, 8'h96, 64'h0, 64'hF0F0F0F0F0F0F0F0, 64'hFF00FF00FF00FF00,
          4'h0, 4'h0, 4'h0, 4'h0, 64'h0FF00FF00FF00FF0, 4'h0, 8'd3},
        // R4: condition field AND3, full mask
        '{2'b10, 8'h80, 8'h00, 64'hFFFF, 64'hFFFF, 64'hFFFF,
          4'b1111, 4'b1010, 4'b1110, 4'b1111, 64'h0, 4'b1010, 8'd4},
        // R5: partial mask keeps unmasked positions
        '{2'b10, 8'h00, 8'hFF, 64'h0, 64'h0, 64'h0,
          4'b1011, 4'b1111, 4'b1111, 4'b0101, 64'h0, 4'b1010, 8'd5},
        // R6: reserved mode gives zero
        '{2'b11, 8'hFF, 8'hFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF,
          4'hF, 4'hF, 4'hF, 4'hF, 64'h0, 4'h0, 8'd6},
        // R10: 0xE2 selects op_dst where op_a is set, else op_b
        '{2'b00, 8'hE2, 8'h00, 64'hAAAAAAAAAAAAAAAA, 64'hFF00FF00FF00FF00, 64'h5555555555555555,
          4'h0, 4'h0, 4'h0, 4'h0, 64'hAA55AA55AA55AA55, 4'h0, 8'd10}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    mode;
    logic [7:0]    tbl_imm;
    logic [7:0]    op_tbl_lo;
    logic [DW-1:0] op_dst, op_a, op_b;
    logic [CW-1:0] cr_dst, cr_b, cr_c, cr_mask;
    logic          out_valid;
    logic [DW-1:0] out_word;
    logic [CW-1:0] out_cr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tri_lut_unit #(.DATA_W(DW), .CRF_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .tbl_imm(tbl_imm), .op_tbl_lo(op_tbl_lo),
        .op_dst(op_dst), .op_a(op_a), .op_b(op_b),
        .cr_dst(cr_dst), .cr_b(cr_b), .cr_c(cr_c), .cr_mask(cr_mask),
        .out_valid(out_valid), .out_word(out_word), .out_cr(out_cr)
    );

    function automatic logic [DW-1:0] ref_word(input logic [7:0] t, input logic [DW-1:0] d,
                                               input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = t[{d[i], a[i], b[i]}];
        return r;
    endfunction

    task automatic check_w(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        in_valid  = 1'b1;
        mode      = v.md;
        tbl_imm   = v.imm;
        op_tbl_lo = v.tbl;
        op_dst    = v.d;
        op_a      = v.a;
        op_b      = v.b;
        cr_dst    = v.cd;
        cr_b      = v.cb;
        cr_c      = v.cc;
        cr_mask   = v.cm;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t v;
        rst_n = 1'b0; in_valid = 1'b0; mode = 2'b00; tbl_imm = 8'h0; op_tbl_lo = 8'h0;
        op_dst = '0; op_a = '0; op_b = '0;
        cr_dst = '0; cr_b = '0; cr_c = '0; cr_mask = '0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check_w("R9 valid", {63'b0, out_valid}, 64'h0);
        check_w("R9 word", out_word, 64'h0);
        check_w("R9 cr", {60'b0, out_cr}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k]);
            check_w($sformatf("R%0d vec%0d valid", VEC[k].rq, k), {63'b0, out_valid}, 64'h1);
            check_w($sformatf("R%0d vec%0d word", VEC[k].rq, k), out_word, VEC[k].ew);
            check_w($sformatf("R%0d vec%0d cr", VEC[k].rq, k), {60'b0, out_cr}, {60'b0, VEC[k].ec});
        end

        // R8 and R7: idle with changed inputs holds result, valid drops
        v = VEC[9];
        drive(v);
        idle();
        op_a = ~op_a; tbl_imm = 8'h00; mode = 2'b11;
        @(posedge clk); #1;
        check_w("R7 valid drop", {63'b0, out_valid}, 64'h0);
        check_w("R8 hold word", out_word, 64'hAA55AA55AA55AA55);
        @(posedge clk); #1;
        check_w("R8 hold word 2", out_word, 64'hAA55AA55AA55AA55);

        // R3: immediate has no effect in register-table mode
        v = VEC[5];
        v.imm = 8'hFF;
        drive(v);
        check_w("R3 imm ignored", out_word, 64'h0FF00FF00FF00FF0);
        // R7: word mode after condition mode clears out_cr
        drive(VEC[6]);
        drive(VEC[1]);
        check_w("R7 cr cleared", {60'b0, out_cr}, 64'h0);

        // R2: every table with random operands, R1 ordering via reference
        for (int t = 0; t < 256; t++) begin
            for (int r = 0; r < 2; r++) begin
                v = VEC[0];
                v.md  = (r == 0) ? 2'b00 : 2'b01;
                v.imm = (r == 0) ? t[7:0] : ~t[7:0];
                v.tbl = t[7:0];
                v.d = {$urandom, $urandom};
                v.a = {$urandom, $urandom};
                v.b = {$urandom, $urandom};
                drive(v);
                check_w($sformatf("R2 table %02h mode %0d", t, r), out_word,
                        ref_word(t[7:0], v.d, v.a, v.b));
            end
        end

        // R4 and R5: random condition fields against reference
        for (int n = 0; n < 32; n++) begin
            logic [CW-1:0] ecr;
            v = VEC[6];
            v.imm = 8'($urandom);
            v.cd = 4'($urandom); v.cb = 4'($urandom); v.cc = 4'($urandom); v.cm = 4'($urandom);
            for (int i = 0; i < CW; i++)
                ecr[i] = v.cm[i] ? v.imm[{v.cd[i], v.cb[i], v.cc[i]}] : v.cd[i];
            drive(v);
            check_w("R4 R5 random field", {60'b0, out_cr}, {60'b0, ecr});
        end

        idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule